// File: doc/BRIEF.md
# Processor System Control Register Bank

This block is the set of 16-bit system registers that a minicomputer CPU exposes in its I/O page. A bus access selects one of sixteen word slots with address bits 4:1, and may be a word read, a word write or a byte write. The block keeps the error registers for memory and CPU, a cache control word, a microbreak word and a stack limit word. It also offers several fixed readouts: a system identifier, a memory-size word computed from an input, and slots that always read zero. A write to the program-interrupt-request slot goes out through a one-cycle strobe with its data. The current request value comes back in through an input so that a read can return it.

Reads are combinational: `rdata` and `nxm` hold the answer in the same cycle as the access. Writes take effect on the rising clock edge. For a byte write the data byte is carried in `wdata[7:0]` and `addrOdd` selects the lane. Each register applies its own byte rule: a merge into the chosen lane, a move of the byte into bits 15:8, or a plain store. Error sources are outside the block. They set error bits through two set inputs, one bit per error.

Top module: `sysreg_bank`

## Requirements
- R1: Slots 006, 007 and 017 (octal) are not implemented. Reading or writing them raises `nxm` and returns zero. A write to one of the read-only slots 000, 001, 010, 011 or 012 also raises `nxm` and changes nothing. With `sel` low there is no `nxm`, `rdata` is zero and no register changes.
- R2: The cache control word (slot 003) takes full word writes. An odd-address byte write replaces bits 15:8 with `wdata[7:0]` and keeps bits 7:0. An even-address byte write replaces bits 7:0 and keeps bits 15:8.
- R3: The stack limit word (slot 016) keeps only bits 15:8, and its low byte always reads as zero. An odd-address byte write stores the byte in bits 15:8. An even-address byte write stores the byte zero-extended, so the stack limit becomes zero.
- R4: The memory error word (slot 002) is write-one-to-clear. The written value is formed with the same lane rule as R3 (odd byte moved to 15:8, even byte zero-extended). Each 1 in it clears the matching bit. Bits are set only through `memErrSet`.
- R5: Any write to the CPU error word (slot 013) clears it. Only bits 7:2 (mask 0x00FC) are implemented; `cpuErrSet` bits outside them are dropped and reads show only them.
- R6: Slot 010 reads `memSize` (in bytes) shifted right by 6, minus one, truncated to 16 bits.
- R7: Slots 000, 001, 004, 005 and 011 read as zero. Writes to slots 004 and 005 are accepted without `nxm` and have no effect.
- R8: Slot 012 reads the system identifier 0x1234 at all times.
- R9: Reset clears the cache control, CPU error, memory error, microbreak and stack limit words and the interrupt-request strobe.
- R10: A write to slot 015 raises `pirqWr` for exactly the cycle after the write edge. `pirqData` carries the value formed with the R3 lane rule. A read of slot 015 returns `pirqIn`.
- R11: The microbreak word (slot 014) uses the same word and byte-merge rules as R2.
- R12: When a set input and a clearing write hit the same error register in the same cycle, the set bits survive the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Access to this bank in the current cycle |
| addrIdx | input | 4 | Word slot, address bits 4:1 |
| addrOdd | input | 1 | Address bit 0, picks the byte lane of a byte write |
| wr | input | 1 | 1 = write, 0 = read |
| byteEn | input | 1 | 1 = byte write, 0 = word access |
| wdata | input | 16 | Write data; byte writes use bits 7:0 |
| memErrSet | input | 16 | Per-bit set requests for the memory error word |
| cpuErrSet | input | 16 | Per-bit set requests for the CPU error word |
| memSize | input | MSW (22) | Installed memory size in bytes |
| pirqIn | input | 16 | Current interrupt-request value, returned on read |
| rdata | output | 16 | Read data, valid in the access cycle |
| nxm | output | 1 | Non-existent slot or refused write, valid in the access cycle |
| pirqWr | output | 1 | One-cycle strobe after a write to slot 015 |
| pirqData | output | 16 | Value written to slot 015 |

## Verification
`rdata` and `nxm` are due in the access cycle itself. The bench therefore samples them one time step after it drives the inputs on the falling edge, before the next rising edge. A write is visible to a read in the following cycle, and `pirqWr` with `pirqData` rises one step after the write edge and falls an edge later. The bench steps its behavioural model at each rising edge and compares the strobe right after it. Set inputs applied together with clearing writes are therefore checked on the edge that handles both.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int DW = 16;

  // Slot numbers (address bits 4:1)
  localparam logic [3:0] SLOT_ERR_LO  = 4'o00;
  localparam logic [3:0] SLOT_ERR_HI  = 4'o01;
  localparam logic [3:0] SLOT_MEMERR  = 4'o02;
  localparam logic [3:0] SLOT_CACHE   = 4'o03;
  localparam logic [3:0] SLOT_MAINT   = 4'o04;
  localparam logic [3:0] SLOT_HITMISS = 4'o05;
  localparam logic [3:0] SLOT_SIZE_LO = 4'o10;
  localparam logic [3:0] SLOT_SIZE_HI = 4'o11;
  localparam logic [3:0] SLOT_SYSID   = 4'o12;
  localparam logic [3:0] SLOT_CPUERR  = 4'o13;
  localparam logic [3:0] SLOT_UBRK    = 4'o14;
  localparam logic [3:0] SLOT_PIRQ    = 4'o15;
  localparam logic [3:0] SLOT_STKLIM  = 4'o16;

  typedef enum logic [1:0] {
    LANE_WORD = 2'd0,
    LANE_LO   = 2'd1,
    LANE_HI   = 2'd2
  } laneT;

  typedef struct packed {
    logic       memErrWr;
    logic       cacheWr;
    logic       ubrkWr;
    logic       cpuErrClr;
    logic       pirqWr;
    logic       stkWr;
    laneT       lane;
    logic       rdEn;
    logic [3:0] slot;
  } strobeT;

  // Byte goes into the selected lane, the other lane keeps its value
  function automatic logic [DW-1:0] laneMerge(laneT lane, logic [DW-1:0] oldV,
                                              logic [DW-1:0] d);
    case (lane)
      LANE_HI: laneMerge = {d[7:0], oldV[7:0]};
      LANE_LO: laneMerge = {oldV[15:8], d[7:0]};
      default: laneMerge = d;
    endcase
  endfunction

  // Odd byte moves to the upper half, even byte is zero-extended
  function automatic logic [DW-1:0] laneShift(laneT lane, logic [DW-1:0] d);
    case (lane)
      LANE_HI: laneShift = {d[7:0], 8'h00};
      LANE_LO: laneShift = {8'h00, d[7:0]};
      default: laneShift = d;
    endcase
  endfunction

endpackage

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
  import sysreg_pkg::*;
#(
  parameter logic [15:0] READ_MAP  = 16'h7F3F,
  parameter logic [15:0] WRITE_MAP = 16'h783C
) (
  input  logic       sel,
  input  logic [3:0] addrIdx,
  input  logic       addrOdd,
  input  logic       wr,
  input  logic       byteEn,
  output strobeT     strobe,
  output logic       nxm
);

  logic readable;
  logic writable;
  logic wrGo;

  always_comb begin
    readable = READ_MAP[addrIdx];
    writable = WRITE_MAP[addrIdx];
    wrGo     = sel & wr & writable;
    nxm      = sel & (wr ? ~writable : ~readable);

    strobe           = '0;
    strobe.slot      = addrIdx;
    strobe.rdEn      = sel & ~wr & readable;
    strobe.memErrWr  = wrGo & (addrIdx == SLOT_MEMERR);
    strobe.cacheWr   = wrGo & (addrIdx == SLOT_CACHE);
    strobe.ubrkWr    = wrGo & (addrIdx == SLOT_UBRK);
    strobe.cpuErrClr = wrGo & (addrIdx == SLOT_CPUERR);
    strobe.pirqWr    = wrGo & (addrIdx == SLOT_PIRQ);
    strobe.stkWr     = wrGo & (addrIdx == SLOT_STKLIM);
    if (!byteEn)      strobe.lane = LANE_WORD;
    else if (addrOdd) strobe.lane = LANE_HI;
    else              strobe.lane = LANE_LO;
  end

endmodule

// File: rtl/sysreg_datapath.sv
module sysreg_datapath
  import sysreg_pkg::*;
#(
  parameter int          MSW          = 22,
  parameter logic [15:0] SYS_ID       = 16'h1234,
  parameter logic [15:0] CPU_ERR_MASK = 16'h00FC,
  parameter logic [15:0] STK_MASK     = 16'hFF00
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobeT         strobe,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  memErrSet,
  input  logic [DW-1:0]  cpuErrSet,
  input  logic [MSW-1:0] memSize,
  input  logic [DW-1:0]  pirqIn,
  output logic [DW-1:0]  rdata,
  output logic           pirqWr,
  output logic [DW-1:0]  pirqData
);

  localparam int SIZE_SHIFT = 6;
  localparam int SIZE_TOP   = SIZE_SHIFT + DW;

  logic [DW-1:0] memErr, cacheCtl, ubrk, cpuErr, stkLim;
  logic [DW-1:0] shiftVal;
  logic [DW-1:0] sizeBlocks;
  logic [DW-1:0] sizeRead;
  logic          unusedSizeBits;

  // Memory size in 64-byte blocks; width picks the slicing variant
  generate
    if (MSW >= SIZE_TOP) begin : gSizeWide
      assign sizeBlocks     = memSize[SIZE_SHIFT +: DW];
      assign unusedSizeBits = ^{memSize[SIZE_SHIFT-1:0], memSize[MSW-1 -: (MSW-SIZE_TOP+1)]};
    end else begin : gSizeNarrow
      assign sizeBlocks     = DW'(memSize >> SIZE_SHIFT);
      assign unusedSizeBits = ^memSize[SIZE_SHIFT-1:0];
    end
  endgenerate

  assign sizeRead = sizeBlocks - 16'd1;
  assign shiftVal = laneShift(strobe.lane, wdata);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memErr   <= '0;
      cacheCtl <= '0;
      ubrk     <= '0;
      cpuErr   <= '0;
      stkLim   <= '0;
      pirqWr   <= 1'b0;
      pirqData <= '0;
    end else begin
      memErr <= (strobe.memErrWr ? (memErr & ~shiftVal) : memErr) | memErrSet;
      cpuErr <= (strobe.cpuErrClr ? '0 : cpuErr) | (cpuErrSet & CPU_ERR_MASK);
      if (strobe.cacheWr) cacheCtl <= laneMerge(strobe.lane, cacheCtl, wdata);
      if (strobe.ubrkWr)  ubrk     <= laneMerge(strobe.lane, ubrk, wdata);
      if (strobe.stkWr)   stkLim   <= shiftVal & STK_MASK;
      pirqWr <= strobe.pirqWr;
      if (strobe.pirqWr)  pirqData <= shiftVal;
    end
  end

  always_comb begin
    rdata = '0;
    if (strobe.rdEn) begin
      case (strobe.slot)
        SLOT_MEMERR:  rdata = memErr;
        SLOT_CACHE:   rdata = cacheCtl;
        SLOT_SIZE_LO: rdata = sizeRead;
        SLOT_SYSID:   rdata = SYS_ID;
        SLOT_CPUERR:  rdata = cpuErr & CPU_ERR_MASK;
        SLOT_UBRK:    rdata = ubrk;
        SLOT_PIRQ:    rdata = pirqIn;
        SLOT_STKLIM:  rdata = stkLim;
        default:      rdata = '0;
      endcase
    end
  end

  AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cacheWr |=> $stable(cacheCtl)); // R2

  AST_STK_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.slot == SLOT_STKLIM) |-> (rdata[7:0] == 8'h00)); // R3

  AST_MEMERR_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((memErr & ~$past(memErr) & ~$past(memErrSet)) == '0)); // R4

  AST_CPUERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cpuErrClr && cpuErrSet == '0) |=> (cpuErr == '0)); // R5

  AST_PIRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pirqWr |=> pirqWr); // R10

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int          MSW    = 22,
  parameter logic [15:0] SYS_ID = 16'h1234
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sel,
  input  logic [3:0]     addrIdx,
  input  logic           addrOdd,
  input  logic           wr,
  input  logic           byteEn,
  input  logic [15:0]    wdata,
  input  logic [15:0]    memErrSet,
  input  logic [15:0]    cpuErrSet,
  input  logic [MSW-1:0] memSize,
  input  logic [15:0]    pirqIn,
  output logic [15:0]    rdata,
  output logic           nxm,
  output logic           pirqWr,
  output logic [15:0]    pirqData
);

  strobeT strobe;

  sysreg_ctrl i_ctrl (
    .sel     (sel),
    .addrIdx (addrIdx),
    .addrOdd (addrOdd),
    .wr      (wr),
    .byteEn  (byteEn),
    .strobe  (strobe),
    .nxm     (nxm)
  );

  sysreg_datapath #(.MSW(MSW), .SYS_ID(SYS_ID)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wdata     (wdata),
    .memErrSet (memErrSet),
    .cpuErrSet (cpuErrSet),
    .memSize   (memSize),
    .pirqIn    (pirqIn),
    .rdata     (rdata),
    .pirqWr    (pirqWr),
    .pirqData  (pirqData)
  );

  AST_UNIMP_NXM: assert property (@(posedge clk) disable iff (!rstN)
    (sel && (addrIdx == 4'o06 || addrIdx == 4'o07 || addrIdx == 4'o17))
      |-> (nxm && rdata == 16'h0000)); // R1

  AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !wr && (addrIdx == SLOT_ERR_LO || addrIdx == SLOT_ERR_HI ||
     addrIdx == SLOT_MAINT || addrIdx == SLOT_HITMISS || addrIdx == SLOT_SIZE_HI))
      |-> (rdata == 16'h0000 && !nxm)); // R7

  AST_SYSID_READ: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !wr && addrIdx == SLOT_SYSID) |-> (rdata == SYS_ID)); // R8

endmodule

// File: tb/test_sysreg_bank.sv
module test_sysreg_bank;

  localparam time CLK_PERIOD = 10;
  localparam int  MSW = 22;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           sel = 1'b0, addrOdd = 1'b0, wr = 1'b0, byteEn = 1'b0;
  logic [3:0]     addrIdx = '0;
  logic [15:0]    wdata = '0, memErrSet = '0, cpuErrSet = '0, pirqIn = 16'h0000;
  logic [MSW-1:0] memSize = 22'h040000;
  logic [15:0]    rdata, pirqData;
  logic           nxm, pirqWr;

  int nChecks = 0;
  int nErrors = 0;

  // behavioural reference state
  logic [15:0] mMem = '0, mCcr = '0, mUbrk = '0, mCpu = '0, mStk = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_bank #(.MSW(MSW)) i_sysreg_bank (
    .clk(clk), .rstN(rstN), .sel(sel), .addrIdx(addrIdx), .addrOdd(addrOdd),
    .wr(wr), .byteEn(byteEn), .wdata(wdata), .memErrSet(memErrSet),
    .cpuErrSet(cpuErrSet), .memSize(memSize), .pirqIn(pirqIn),
    .rdata(rdata), .nxm(nxm), .pirqWr(pirqWr), .pirqData(pirqData)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mergeB(input logic b, input logic odd,
                                         input logic [15:0] o, input logic [15:0] d);
    if (!b) return d;
    return odd ? {d[7:0], o[7:0]} : {o[15:8], d[7:0]};
  endfunction

  function automatic logic [15:0] shiftB(input logic b, input logic odd, input logic [15:0] d);
    if (!b) return d;
    return odd ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
  endfunction

  function automatic logic [16:0] expRead(input logic [3:0] idx);
    int blocks;
    case (idx)
      4'o00, 4'o01, 4'o04, 4'o05, 4'o11: return {1'b0, 16'h0000};
      4'o02: return {1'b0, mMem};
      4'o03: return {1'b0, mCcr};
      4'o10: begin
        blocks = int'(memSize) / 64;
        return {1'b0, 16'((blocks - 1) & 16'hFFFF)};
      end
      4'o12: return {1'b0, 16'h1234};
      4'o13: return {1'b0, mCpu & 16'h00FC};
      4'o14: return {1'b0, mUbrk};
      4'o15: return {1'b0, pirqIn};
      4'o16: return {1'b0, mStk};
      default: return {1'b1, 16'h0000};
    endcase
  endfunction

  // One bus cycle: drive at falling edge, check combinational answer,
  // step model at the rising edge, then check the strobe.
  task automatic xfer(input logic s, input logic w, input logic b, input logic odd,
                      input logic [3:0] idx, input logic [15:0] d,
                      input logic [15:0] ms, input logic [15:0] cs, input string tag);
    logic [16:0] er;
    logic        expNxm, expPirq;
    logic [15:0] expPd;
    @(negedge clk);
    sel = s; wr = w; byteEn = b; addrOdd = odd; addrIdx = idx; wdata = d;
    memErrSet = ms; cpuErrSet = cs;
    #1;
    er = expRead(idx);
    if (!s) expNxm = 1'b0;
    else if (w) expNxm = (idx inside {4'o00, 4'o01, 4'o06, 4'o07, 4'o10, 4'o11, 4'o12, 4'o17});
    else expNxm = er[16];
    chk({tag, " rdata"}, rdata, (s && !w) ? er[15:0] : 16'h0000);
    chk({tag, " nxm"}, {15'd0, nxm}, {15'd0, expNxm});
    @(posedge clk);
    expPirq = s && w && idx == 4'o15;
    expPd   = shiftB(b, odd, d);
    if (s && w) begin
      case (idx)
        4'o02: mMem = mMem & ~shiftB(b, odd, d);
        4'o03: mCcr = mergeB(b, odd, mCcr, d);
        4'o13: mCpu = '0;
        4'o14: mUbrk = mergeB(b, odd, mUbrk, d);
        4'o16: mStk = shiftB(b, odd, d) & 16'hFF00;
        default: ;
      endcase
    end
    mMem = mMem | ms;
    mCpu = mCpu | (cs & 16'h00FC);
    #1;
    chk({tag, " pirqWr"}, {15'd0, pirqWr}, {15'd0, expPirq});
    if (expPirq) chk({tag, " pirqData"}, pirqData, expPd);
    sel = 1'b0; wr = 1'b0; memErrSet = '0; cpuErrSet = '0;
  endtask

  task automatic rd(input logic [3:0] idx, input string tag);
    xfer(1'b1, 1'b0, 1'b0, 1'b0, idx, 16'h0, 16'h0, 16'h0, tag);
  endtask

  task automatic wrw(input logic [3:0] idx, input logic [15:0] d, input string tag);
    xfer(1'b1, 1'b1, 1'b0, 1'b0, idx, d, 16'h0, 16'h0, tag);
  endtask

  task automatic wrb(input logic [3:0] idx, input logic odd, input logic [7:0] d, input string tag);
    xfer(1'b1, 1'b1, 1'b1, odd, idx, {8'hEE, d}, 16'h0, 16'h0, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    mMem = '0; mCcr = '0; mUbrk = '0; mCpu = '0; mStk = '0;
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    nErrors++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    doReset();
    // R9: reset state
    foreach (i_idx[k]) ;
    rd(4'o02, "R9 memErr"); rd(4'o03, "R9 cache"); rd(4'o13, "R9 cpuErr");
    rd(4'o14, "R9 ubrk");  rd(4'o16, "R9 stk");    rd(4'o12, "R8 sysid");

    // R2: cache merge rules
    wrw(4'o03, 16'hA5C3, "R2 word");   rd(4'o03, "R2 rd word");
    wrb(4'o03, 1'b1, 8'h7E, "R2 odd"); rd(4'o03, "R2 rd odd");
    wrb(4'o03, 1'b0, 8'h11, "R2 even"); rd(4'o03, "R2 rd even");

    // R11: microbreak merge rules
    wrw(4'o14, 16'h1357, "R11 word");   rd(4'o14, "R11 rd word");
    wrb(4'o14, 1'b1, 8'hC4, "R11 odd"); rd(4'o14, "R11 rd odd");
    wrb(4'o14, 1'b0, 8'h9A, "R11 even"); rd(4'o14, "R11 rd even");

    // R3: stack limit
    wrw(4'o16, 16'h1234, "R3 word");   rd(4'o16, "R3 rd word");
    wrb(4'o16, 1'b1, 8'h56, "R3 odd"); rd(4'o16, "R3 rd odd");
    wrb(4'o16, 1'b0, 8'h78, "R3 even"); rd(4'o16, "R3 rd even");

    // R4: memory error write-one-to-clear
    xfer(1'b0, 1'b0, 1'b0, 1'b0, 4'o00, 16'h0, 16'hFFFF, 16'h0, "R4 set");
    rd(4'o02, "R4 rd set");
    wrw(4'o02, 16'h00F0, "R4 word"); rd(4'o02, "R4 rd word");
    wrb(4'o02, 1'b1, 8'h0F, "R4 odd"); rd(4'o02, "R4 rd odd");
    wrb(4'o02, 1'b0, 8'h0F, "R4 even"); rd(4'o02, "R4 rd even");

    // R5: CPU error clear and mask
    xfer(1'b0, 1'b0, 1'b0, 1'b0, 4'o00, 16'h0, 16'h0, 16'hFFFF, "R5 set");
    rd(4'o13, "R5 rd mask");
    wrb(4'o13, 1'b0, 8'h00, "R5 clear"); rd(4'o13, "R5 rd clear");

    // R12: set beats simultaneous clear
    xfer(1'b1, 1'b1, 1'b0, 1'b0, 4'o13, 16'hFFFF, 16'h0, 16'h0004, "R12 cpu");
    rd(4'o13, "R12 rd cpu");
    xfer(1'b1, 1'b1, 1'b0, 1'b0, 4'o02, 16'hFFFF, 16'h0100, 16'h0, "R12 mem");
    rd(4'o02, "R12 rd mem");

    // R6: memory size readout
    rd(4'o10, "R6 256k");
    memSize = 22'h3FFFC0; rd(4'o10, "R6 max");
    memSize = 22'h000000; rd(4'o10, "R6 zero");

    // R7: zero slots, ignored writes
    rd(4'o00, "R7 lo"); rd(4'o01, "R7 hi"); rd(4'o04, "R7 maint");
    rd(4'o05, "R7 hitmiss"); rd(4'o11, "R7 sizehi");
    wrw(4'o04, 16'hFFFF, "R7 wr maint"); rd(4'o04, "R7 rd maint");
    wrb(4'o05, 1'b1, 8'hFF, "R7 wr hitmiss"); rd(4'o05, "R7 rd hitmiss");

    // R8 / R1: read-only slots refuse writes
    wrw(4'o12, 16'h0000, "R8 wr sysid"); rd(4'o12, "R8 rd sysid");
    wrw(4'o00, 16'h1111, "R1 wr lo"); wrw(4'o10, 16'h2222, "R1 wr size");

    // R1: unimplemented slots and deselected access
    rd(4'o06, "R1 rd 06"); rd(4'o07, "R1 rd 07"); rd(4'o17, "R1 rd 17");
    wrw(4'o06, 16'h1, "R1 wr 06"); wrw(4'o17, 16'h1, "R1 wr 17");
    xfer(1'b0, 1'b1, 1'b0, 1'b0, 4'o03, 16'hDEAD, 16'h0, 16'h0, "R1 desel");
    rd(4'o03, "R1 rd after desel");

    // R10: interrupt request port
    wrw(4'o15, 16'hBEEF, "R10 word");
    wrb(4'o15, 1'b1, 8'h42, "R10 odd");
    wrb(4'o15, 1'b0, 8'h42, "R10 even");
    pirqIn = 16'h0A50; rd(4'o15, "R10 rd");

    // R9: reset in mid-run
    wrw(4'o03, 16'hFFFF, "R9 pre");
    doReset();
    rd(4'o03, "R9 cache after"); rd(4'o14, "R9 ubrk after");
    rd(4'o16, "R9 stk after");  rd(4'o02, "R9 mem after");

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  int i_idx[1];

endmodule